// File: doc/BRIEF.md
# Interrupt Coalescing Credit Controller

This block is one interrupt resource. It turns single-cycle assert events into single-cycle message pulses. Three things gate the message: a mask bit, a countdown hold-off timer, and a record of unsent events. The timer is reloaded from a programmed value each time a message goes out and counts down on a microsecond tick. While it is non-zero, events are held rather than sent. Once it reaches zero, a held event is sent straight away.

A signed credit counter counts the messages sent. Software returns credits by writing a magnitude, which the block subtracts from the count rather than storing. The upper bits of that same write word can unmask the resource and restart the hold-off timer. A write that brings the count to zero clears the status output and discards any held event.

The register window covers 32 bytes, which is eight 32-bit words addressed by a word index. An optional auto-mask setting masks the resource each time a message is sent. Each message pulse carries the resource index given as a parameter.

Top module: `irq_coal_credit_ctl`

## Requirements
- R1: After reset the mask reads 1. The hold-off value, auto-mask bit, credit count and timer read 0. `msg_o` and `pend_o` are low.
- R2: While the mask is 1, no message is sent. An incoming event is held, and `pend_o` rises in the cycle after the event.
- R3: Writing 0 to the mask word (slot 0, bit 0) while an event is held sends the message two cycles after the write cycle. With nothing held, the next event sends it.
- R4: With a hold-off value of 0 and the mask at 0, every event produces a message pulse in the cycle after the event, including events on back-to-back cycles.
- R5: Each message loads the timer (slot 4, read-only) from the hold-off value (slot 1). The timer drops by 1 per tick and holds without ticks. A held event is sent in the cycle after the timer reaches 0, so `msg_o` rises two cycles after the final tick cycle.
- R6: Each message adds 1 to the credit count (slot 3, read as 16 bits zero-extended).
- R7: A write to slot 3 subtracts bits 14:0 of the data from the credit count. The result wraps as a signed 16-bit value, so 0 minus 2 reads 0xFFFE.
- R8: A credit write that leaves the count at 0 clears `pend_o` and discards any held event, so a later unmask sends nothing.
- R9: In a credit write, bit 16 clears the mask and bit 17 reloads the timer from the hold-off value. Neither bit is stored. Setting both rearms the resource.
- R10: With the auto-mask bit (slot 2, bit 0) at 1, the mask reads 1 after every message, so the next event is held.
- R11: Slots 5 to 7 read 0. A hold-off write keeps only the low 6 bits.
- R12: `msg_idx_o` equals the resource index parameter whenever `msg_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 1 | Interrupt assert event pulse |
| tick_i | input | 1 | Microsecond tick for the hold-off timer |
| wr_en_i | input | 1 | Register write strobe |
| wr_slot_i | input | 3 | Word index of the write within the window |
| wr_data_i | input | 32 | Write data |
| rd_slot_i | input | 3 | Word index of the read |
| rd_data_o | output | 32 | Read data, combinational |
| msg_o | output | 1 | Single-cycle message pulse |
| msg_idx_o | output | 11 | Resource index carried with the message |
| pend_o | output | 1 | Pending status: set by events, cleared when credits are returned to zero |

## Verification
The bench targets the handoff between a held event and the timer reaching zero. A design that compares the timer one cycle late, or ignores the held event, delays or loses that message. It returns credits to exactly zero while an event is held and then unmasks. A design that forgets to discard the held event sends a spurious message at that point. It drives the count negative to expose a design that saturates instead of wrapping. It also combines auto-mask with unmask and rearm writes, which catches a design that stores the strobe bits or lets the unmask override the auto-mask.

// File: rtl/irq_coal_pkg.sv
package irq_coal_pkg;

   // Register window geometry: 32 bytes, 32-bit words.
   localparam int WIN_BYTES  = 32;
   localparam int WORD_BYTES = 4;
   localparam int WIN_SLOTS  = WIN_BYTES / WORD_BYTES;

   // Word slots within the window.
   localparam logic [2:0] SLOT_MASK  = 3'd0;
   localparam logic [2:0] SLOT_COAL  = 3'd1;
   localparam logic [2:0] SLOT_AMASK = 3'd2;
   localparam logic [2:0] SLOT_CRED  = 3'd3;
   localparam logic [2:0] SLOT_TIMER = 3'd4;

   // Strobe bits carried in a credit write.
   localparam int UNMASK_BIT = 16;
   localparam int RELOAD_BIT = 17;

   // Decoded write command handed from the register decoder to the datapath.
   typedef struct packed {
      logic mask_wr;
      logic mask_val;
      logic cred_wr;
      logic unmask;
      logic reload;
   } wr_cmd_t;

endpackage

// File: rtl/irq_coal_regs.sv
module irq_coal_regs
   import irq_coal_pkg::*;
#(
   parameter int COAL_W = 6,
   parameter int CRED_W = 16,
   parameter int DATA_W = 32,
   parameter int SLOT_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SLOT_W-1:0] wr_slot,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [SLOT_W-1:0] rd_slot,
   input  logic              mask_cur,
   input  logic [CRED_W-1:0] cred_cur,
   input  logic [COAL_W-1:0] tmr_cur,
   output wr_cmd_t           cmd,
   output logic [CRED_W-2:0] dec_mag,
   output logic [COAL_W-1:0] coal_q,
   output logic              amask_q,
   output logic [DATA_W-1:0] rd_data
);

   localparam int MAG_W = CRED_W - 1;

   logic hit_mask, hit_coal, hit_amask, hit_cred;

   assign hit_mask  = wr_en && (wr_slot == SLOT_W'(SLOT_MASK));
   assign hit_coal  = wr_en && (wr_slot == SLOT_W'(SLOT_COAL));
   assign hit_amask = wr_en && (wr_slot == SLOT_W'(SLOT_AMASK));
   assign hit_cred  = wr_en && (wr_slot == SLOT_W'(SLOT_CRED));

   always_comb begin
      cmd          = '0;
      cmd.mask_wr  = hit_mask;
      cmd.mask_val = wr_data[0];
      cmd.cred_wr  = hit_cred;
      cmd.unmask   = hit_cred && wr_data[UNMASK_BIT];
      cmd.reload   = hit_cred && wr_data[RELOAD_BIT];
   end

   assign dec_mag = wr_data[MAG_W-1:0];

   // Bits of the write word that no register takes.
   logic unused_wr_bits;
   assign unused_wr_bits = ^{wr_data[DATA_W-1:RELOAD_BIT+1],
                             wr_data[UNMASK_BIT-1:MAG_W]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         coal_q  <= '0;
         amask_q <= 1'b0;
      end else begin
         if (hit_coal)  coal_q  <= wr_data[COAL_W-1:0];
         if (hit_amask) amask_q <= wr_data[0];
      end
   end

   always_comb begin
      rd_data = '0;
      unique case (rd_slot)
         SLOT_W'(SLOT_MASK):  rd_data = DATA_W'(mask_cur);
         SLOT_W'(SLOT_COAL):  rd_data = DATA_W'(coal_q);
         SLOT_W'(SLOT_AMASK): rd_data = DATA_W'(amask_q);
         SLOT_W'(SLOT_CRED):  rd_data = DATA_W'(cred_cur);
         SLOT_W'(SLOT_TIMER): rd_data = DATA_W'(tmr_cur);
         default:             rd_data = '0;
      endcase
   end

   // Strobes are never stored: slot 3 carries no flag bits when read.
   a_r9_flags_not_stored: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_slot == SLOT_W'(SLOT_CRED)) |-> (rd_data[DATA_W-1:CRED_W] == '0));

   a_r11_coal_written: assert property (@(posedge clk) disable iff (!rst_n)
      hit_coal |=> (coal_q == $past(wr_data[COAL_W-1:0])));

endmodule

// File: rtl/irq_coal_timer.sv
module irq_coal_timer #(
   parameter int COAL_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [COAL_W-1:0] load_val,
   input  logic              tick,
   output logic [COAL_W-1:0] tmr_q,
   output logic              tmr_zero
);

   assign tmr_zero = (tmr_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tmr_q <= '0;
      end else if (load) begin
         tmr_q <= load_val;
      end else if (tick && !tmr_zero) begin
         tmr_q <= tmr_q - 1'b1;
      end
   end

   a_r5_tick_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && tick && tmr_q != '0) |=> (tmr_q == $past(tmr_q) - 1'b1));

   a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !tick) |=> $stable(tmr_q));

   a_r9_reload: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (tmr_q == $past(load_val)));

endmodule

// File: rtl/irq_coal_credit.sv
module irq_coal_credit #(
   parameter int CRED_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              inc,
   input  logic              dec,
   input  logic [CRED_W-2:0] dec_mag,
   output logic [CRED_W-1:0] cred_q,
   output logic              zero_by_write
);

   logic [CRED_W-1:0] sub_val;
   logic [CRED_W-1:0] cred_next;

   assign sub_val       = dec ? {1'b0, dec_mag} : '0;
   assign cred_next     = cred_q + CRED_W'(inc) - sub_val;
   assign zero_by_write = dec && (cred_next == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) cred_q <= '0;
      else        cred_q <= cred_next;
   end

   a_r6_send_adds_one: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !dec) |=> (cred_q == $past(cred_q) + 1'b1));

   a_r7_write_subtracts: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !inc) |=> (cred_q == CRED_W'($past(cred_q) - {1'b0, $past(dec_mag)})));

   a_r7_no_change: assert property (@(posedge clk) disable iff (!rst_n)
      (!dec && !inc) |=> $stable(cred_q));

endmodule

// File: rtl/irq_coal_gate.sv
module irq_coal_gate
   import irq_coal_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    evt,
   input  wr_cmd_t cmd,
   input  logic    amask,
   input  logic    tmr_zero,
   input  logic    cred_clear,
   output logic    fire,
   output logic    mask_q,
   output logic    held_q,
   output logic    stat_q,
   output logic    msg_q
);

   assign fire = (held_q || evt) && !mask_q && tmr_zero;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q <= 1'b1;
         held_q <= 1'b0;
         stat_q <= 1'b0;
         msg_q  <= 1'b0;
      end else begin
         msg_q <= fire;

         if (fire)            held_q <= 1'b0;
         else if (evt)        held_q <= 1'b1;
         else if (cred_clear) held_q <= 1'b0;

         if (evt)             stat_q <= 1'b1;
         else if (cred_clear) stat_q <= 1'b0;

         if (cmd.mask_wr)         mask_q <= cmd.mask_val;
         else if (fire && amask)  mask_q <= 1'b1;
         else if (cmd.unmask)     mask_q <= 1'b0;
      end
   end

   a_r2_masked_event_held: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q && evt) |=> held_q);

   a_r10_auto_mask: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && amask && !cmd.mask_wr) |=> mask_q);

   a_r8_discard: assert property (@(posedge clk) disable iff (!rst_n)
      (cred_clear && !evt) |=> (!held_q && !stat_q));

endmodule

// File: rtl/irq_coal_credit_ctl.sv
module irq_coal_credit_ctl
   import irq_coal_pkg::*;
#(
   parameter int COAL_W    = 6,
   parameter int CRED_W    = 16,
   parameter int DATA_W    = 32,
   parameter int IDX_W     = 11,
   parameter int RES_INDEX = 0,
   localparam int SLOT_W   = $clog2(WIN_SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              evt_i,
   input  logic              tick_i,
   input  logic              wr_en_i,
   input  logic [SLOT_W-1:0] wr_slot_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic [SLOT_W-1:0] rd_slot_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              msg_o,
   output logic [IDX_W-1:0]  msg_idx_o,
   output logic              pend_o
);

   generate
      if (CRED_W < 2 || CRED_W > UNMASK_BIT) begin : g_bad_cred
         $error("CRED_W must lie in 2..16");
      end
      if (COAL_W < 1 || COAL_W >= CRED_W) begin : g_bad_coal
         $error("COAL_W must lie in 1..CRED_W-1");
      end
      if (DATA_W < RELOAD_BIT + 2) begin : g_bad_data
         $error("DATA_W too narrow for the flag bits");
      end
      if (RES_INDEX < 0 || RES_INDEX >= (1 << IDX_W)) begin : g_bad_idx
         $error("RES_INDEX does not fit in IDX_W");
      end
   endgenerate

   wr_cmd_t           cmd;
   logic [CRED_W-2:0] dec_mag;
   logic [COAL_W-1:0] coal_q;
   logic              amask_q;
   logic [COAL_W-1:0] tmr_q;
   logic              tmr_zero;
   logic [CRED_W-1:0] cred_q;
   logic              cred_clear;
   logic              fire, mask_q, held_q, stat_q, msg_q;

   irq_coal_regs #(
      .COAL_W (COAL_W),
      .CRED_W (CRED_W),
      .DATA_W (DATA_W),
      .SLOT_W (SLOT_W)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en_i),
      .wr_slot  (wr_slot_i),
      .wr_data  (wr_data_i),
      .rd_slot  (rd_slot_i),
      .mask_cur (mask_q),
      .cred_cur (cred_q),
      .tmr_cur  (tmr_q),
      .cmd      (cmd),
      .dec_mag  (dec_mag),
      .coal_q   (coal_q),
      .amask_q  (amask_q),
      .rd_data  (rd_data_o)
   );

   irq_coal_timer #(.COAL_W(COAL_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (fire || cmd.reload),
      .load_val (coal_q),
      .tick     (tick_i),
      .tmr_q    (tmr_q),
      .tmr_zero (tmr_zero)
   );

   irq_coal_credit #(.CRED_W(CRED_W)) u_credit (
      .clk           (clk),
      .rst_n         (rst_n),
      .inc           (fire),
      .dec           (cmd.cred_wr),
      .dec_mag       (dec_mag),
      .cred_q        (cred_q),
      .zero_by_write (cred_clear)
   );

   irq_coal_gate u_gate (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt        (evt_i),
      .cmd        (cmd),
      .amask      (amask_q),
      .tmr_zero   (tmr_zero),
      .cred_clear (cred_clear),
      .fire       (fire),
      .mask_q     (mask_q),
      .held_q     (held_q),
      .stat_q     (stat_q),
      .msg_q      (msg_q)
   );

   assign msg_o     = msg_q;
   assign msg_idx_o = msg_q ? IDX_W'(RES_INDEX) : '0;
   assign pend_o    = stat_q;

   // A message only leaves after a cycle in which the timer read zero.
   a_r5_needs_idle_timer: assert property (@(posedge clk) disable iff (!rst_n)
      msg_o |-> $past(tmr_zero));

   // A non-zero hold-off value forbids back-to-back messages.
   a_r5_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_o && $past(coal_q) != '0) |=> !msg_o);

   // A message needs the mask clear in the cycle that sent it.
   a_r2_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      msg_o |-> !$past(mask_q));

endmodule

// File: tb/irq_coal_credit_ctl_test.sv
module irq_coal_credit_ctl_test;

   localparam int RES = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        evt = 1'b0, tick = 1'b0, wr_en = 1'b0;
   logic [2:0]  wr_slot = '0, rd_slot = '0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic        msg, pend;
   logic [10:0] msg_idx;

   int errs = 0, checks = 0, cyc = 0;
   bit done = 1'b0;
   int expq[$];

   irq_coal_credit_ctl #(.RES_INDEX(RES)) uut (
      .clk(clk), .rst_n(rst_n), .evt_i(evt), .tick_i(tick),
      .wr_en_i(wr_en), .wr_slot_i(wr_slot), .wr_data_i(wr_data),
      .rd_slot_i(rd_slot), .rd_data_o(rd_data), .msg_o(msg),
      .msg_idx_o(msg_idx), .pend_o(pend)
   );

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // Monitor: pops the expected cycle of every message pulse.
   always @(negedge clk) begin
      if (rst_n && msg) begin
         if (expq.size() == 0) begin
            chk(1'b0, "R2/R8", "unexpected message at cycle", cyc, -1);
         end else begin
            int e;
            e = expq.pop_front();
            chk(e == cyc, "R3/R4/R5", "message cycle", cyc, e);
         end
         chk(msg_idx == 11'(RES), "R12", "message index", msg_idx, RES);
      end
   end

   // One cycle of stimulus; off > 0 books a message at cycle now+off.
   task automatic step(input bit e, input bit t, input bit w,
                       input logic [2:0] s, input logic [31:0] d, input int off);
      @(negedge clk);
      evt = e; tick = t; wr_en = w; wr_slot = s; wr_data = d;
      if (off > 0) expq.push_back(cyc + off);
      @(posedge clk);
      #1;
      evt = 1'b0; tick = 1'b0; wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] s, input logic [31:0] exp, input string tag);
      @(negedge clk);
      rd_slot = s;
      #1;
      chk(rd_data == exp, tag, $sformatf("read slot %0d", s), rd_data, exp);
   endtask

   task automatic summary;
      $display("Result: errors=%0d of %0d checks", errs, checks);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errs++;
         $display("FAIL watchdog: actual=hung expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset state
      rd(3'd0, 32'd1, "R1");
      rd(3'd1, 32'd0, "R1");
      rd(3'd2, 32'd0, "R1");
      rd(3'd3, 32'd0, "R1");
      rd(3'd4, 32'd0, "R1");
      chk(msg == 1'b0, "R1", "msg after reset", msg, 0);
      chk(pend == 1'b0, "R1", "pend after reset", pend, 0);

      // R2 masked event is held
      step(1, 0, 0, 3'd0, 0, 0);
      chk(pend == 1'b1, "R2", "pend after masked event", pend, 1);
      repeat (3) step(0, 0, 0, 3'd0, 0, 0);

      // R3 unmask sends the held event two cycles on
      step(0, 0, 1, 3'd0, 32'd0, 2);
      repeat (2) step(0, 0, 0, 3'd0, 0, 0);

      // R4 back-to-back events with no hold-off
      step(1, 0, 0, 3'd0, 0, 1);
      step(1, 0, 0, 3'd0, 0, 1);
      step(1, 0, 0, 3'd0, 0, 1);
      step(0, 0, 0, 3'd0, 0, 0);
      rd(3'd3, 32'd4, "R6");

      // R8 return all credits with an event held: event discarded
      step(0, 0, 1, 3'd0, 32'd1, 0);
      step(1, 0, 0, 3'd0, 0, 0);
      step(0, 0, 1, 3'd3, 32'd4, 0);
      chk(pend == 1'b0, "R8", "pend after credits zeroed", pend, 0);
      step(0, 0, 1, 3'd0, 32'd0, 0);
      repeat (3) step(0, 0, 0, 3'd0, 0, 0);
      rd(3'd3, 32'd0, "R8");

      // R7 signed wrap below zero
      step(0, 0, 1, 3'd3, 32'd2, 0);
      rd(3'd3, 32'h0000_FFFE, "R7");

      // R5 hold-off timer
      step(0, 0, 1, 3'd1, 32'd3, 0);
      step(1, 0, 0, 3'd0, 0, 1);
      rd(3'd4, 32'd3, "R5");
      step(1, 0, 0, 3'd0, 0, 0);
      repeat (2) step(0, 0, 0, 3'd0, 0, 0);
      rd(3'd4, 32'd3, "R5");
      step(0, 1, 0, 3'd0, 0, 0);
      step(0, 1, 0, 3'd0, 0, 0);
      rd(3'd4, 32'd1, "R5");
      step(0, 1, 0, 3'd0, 0, 2);
      repeat (2) step(0, 0, 0, 3'd0, 0, 0);
      rd(3'd3, 32'd0, "R6");
      rd(3'd4, 32'd3, "R5");

      // R9 timer reload strobe
      step(0, 1, 0, 3'd0, 0, 0);
      rd(3'd4, 32'd2, "R9");
      step(0, 0, 1, 3'd3, 32'h0002_0000, 0);
      rd(3'd4, 32'd3, "R9");
      rd(3'd3, 32'd0, "R9");

      // R10 auto-mask, then unmask strobe and rearm
      step(0, 0, 1, 3'd1, 32'd0, 0);
      step(0, 0, 1, 3'd3, 32'h0002_0000, 0);
      rd(3'd4, 32'd0, "R9");
      step(0, 0, 1, 3'd2, 32'd1, 0);
      step(1, 0, 0, 3'd0, 0, 1);
      rd(3'd0, 32'd1, "R10");
      step(1, 0, 0, 3'd0, 0, 0);
      repeat (2) step(0, 0, 0, 3'd0, 0, 0);
      step(0, 0, 1, 3'd3, 32'h0001_0000, 2);
      repeat (2) step(0, 0, 0, 3'd0, 0, 0);
      rd(3'd0, 32'd1, "R10");
      step(0, 0, 1, 3'd3, 32'h0003_0000, 0);
      rd(3'd0, 32'd0, "R9");
      step(1, 0, 0, 3'd0, 0, 1);
      step(0, 0, 0, 3'd0, 0, 0);
      rd(3'd3, 32'd3, "R6");

      // R11 reserved slots and hold-off width
      rd(3'd5, 32'd0, "R11");
      rd(3'd7, 32'd0, "R11");
      step(0, 0, 1, 3'd1, 32'hFFFF_FFC5, 0);
      rd(3'd1, 32'd5, "R11");

      repeat (4) step(0, 0, 0, 3'd0, 0, 0);
      chk(expq.size() == 0, "R3/R4/R5", "messages still owed", expq.size(), 0);
      done = 1'b1;
      summary();
      $finish;
   end

endmodule